// File: doc/BRIEF.md
# Segmented 32-bit Outbound Window Translator

This block decides whether a CPU-side address falls inside one programmable outbound window. For every address inside the window it produces a 32-bit bus address and an endpoint number. The window size is a power of two between 256 MB and 4 GB, programmed as its base-2 logarithm, and the window is naturally aligned. Only the address bits inside the window are kept. The bus-address bits at and above the size boundary come from a programmed replacement value, so every forwarded access becomes a 32-bit bus access.

The window is divided into 256 equal segments. The segment index is the eight offset bits just below the size boundary. A 256-entry table, written through a simple write port, gives the endpoint number for each segment. The table can be rewritten while lookups continue, so software can assign space to endpoints at segment granularity. For example, a 2 GB window has 8 MB segments and a 256 MB window has 1 MB segments. The block does not protect any part of the range. The topmost 64 KB of the window is forwarded like every other part of it.

Results are registered, so the outputs appear one clock after the address is presented.

Top module: `seg_xlate_win`

## Requirements
- R1: After reset, `hit`, `bus_addr` and `pe_num` are zero and every table entry holds endpoint 0.
- R2: An address hits when `win_en` is 1, `win_log2` (unsigned, size = 2^win_log2 bytes) is between 28 and 32 inclusive, and `cpu_addr` bits [CPU_AW-1:win_log2] equal the same bits of `win_base`.
- R3: When `win_en` is 0, or `win_log2` is below 28 or above 32, no address hits.
- R4: On a hit, `bus_addr` bits [win_log2-1:0] equal the same bits of `cpu_addr`, and bits [31:win_log2] equal the same bits of `repl_hi`. With `win_log2` = 32, `bus_addr` is `cpu_addr[31:0]`.
- R5: On a hit, the segment index is `cpu_addr[win_log2-1:win_log2-8]`, and `pe_num` is the table entry at that index.
- R6: When `tbl_we` is 1 at a clock edge, entry `tbl_idx` takes `tbl_pe`. A lookup presented in that same cycle sees the old entry. Lookups in later cycles see the new one.
- R7: Outputs change only at a clock edge and reflect the inputs present at that edge (one cycle of latency).
- R8: On a miss, `bus_addr` and `pe_num` are zero.
- R9: Addresses in the top 64 KB of the window, up to base + size - 1, hit and are translated like any other address in the window. The address base + size misses.
- R10: The bits of `win_base` below `win_log2` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | CPU_AW | CPU-side address to decode |
| win_en | input | 1 | Window enable |
| win_base | input | CPU_AW | Window base; only bits at and above the size boundary are used |
| win_log2 | input | 6 | Base-2 logarithm of the window size |
| repl_hi | input | 32 | Replacement value for the bus-address bits above the window offset |
| tbl_we | input | 1 | Segment table write enable |
| tbl_idx | input | 8 | Segment table entry to write |
| tbl_pe | input | PE_W | Endpoint number to write |
| hit | output | 1 | Registered hit flag |
| bus_addr | output | 32 | Registered translated bus address |
| pe_num | output | PE_W | Registered endpoint number |

## Verification
The assertions assume the configuration inputs and `cpu_addr` are stable, known values at every clock edge after reset. They also assume any `win_log2` outside 28..32 is only ever meant to disable the window. The stimulus drives all inputs on the falling edge. It draws `win_log2` from a range slightly wider than the legal one, so both the disable path and the legal sizes get exercised. Most random addresses are formed from the window base plus a random in-window offset, so that hits are frequent. Table writes are mixed in at random, including writes to the segment being looked up in the same cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int BUS_AW   = 32;
    localparam int SEG_CNT  = 256;
    localparam int SEG_W    = $clog2(SEG_CNT);
    localparam int LOG2_W   = 6;
    localparam int MIN_LOG2 = 28;
    localparam int MAX_LOG2 = BUS_AW;

    typedef logic [BUS_AW-1:0] bus_addr_t;
    typedef logic [SEG_W-1:0]  seg_idx_t;
    typedef logic [LOG2_W-1:0] log2_t;
endpackage

// File: rtl/seg_xlate_match.sv
module seg_xlate_match
    import seg_xlate_pkg::*;
#(
    parameter int CPU_AW = 48
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              win_en,
    input  logic [CPU_AW-1:0] win_base,
    input  log2_t             win_log2,
    input  bus_addr_t         repl_hi,
    output logic              hit_c,
    output bus_addr_t         bus_c,
    output seg_idx_t          seg_c
);
    localparam log2_t SEG_SHIFT = log2_t'(SEG_W);

    logic              size_ok;
    logic [CPU_AW-1:0] lo_mask;
    bus_addr_t         mask32;
    bus_addr_t         off32;
    log2_t             seg_sh;

    always_comb begin
        size_ok = (win_log2 >= log2_t'(MIN_LOG2)) && (win_log2 <= log2_t'(MAX_LOG2));
        lo_mask = size_ok ? ((CPU_AW'(1) << win_log2) - CPU_AW'(1)) : '0;
        mask32  = lo_mask[BUS_AW-1:0];
        off32   = cpu_addr[BUS_AW-1:0] & mask32;
        seg_sh  = size_ok ? (win_log2 - SEG_SHIFT) : '0;
        hit_c   = win_en && size_ok && (((cpu_addr ^ win_base) & ~lo_mask) == '0);
        bus_c   = (repl_hi & ~mask32) | off32;
        seg_c   = seg_idx_t'(off32 >> seg_sh);
    end
endmodule

// File: rtl/seg_xlate_table.sv
module seg_xlate_table
    import seg_xlate_pkg::*;
#(
    parameter int PE_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  seg_idx_t        wr_idx,
    input  logic [PE_W-1:0] wr_pe,
    input  seg_idx_t        rd_idx,
    output logic [PE_W-1:0] rd_pe
);
    logic [PE_W-1:0] tbl_d [SEG_CNT];
    logic [PE_W-1:0] tbl_q [SEG_CNT];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx] = wr_pe;
        end
        rd_pe = tbl_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '{default: '0};
        end else begin
            tbl_q <= tbl_d;
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl_q[$past(wr_idx)] == $past(wr_pe))); // R6
endmodule

// File: rtl/seg_xlate_win.sv
module seg_xlate_win
    import seg_xlate_pkg::*;
#(
    parameter int CPU_AW = 48,
    parameter int PE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              win_en,
    input  logic [CPU_AW-1:0] win_base,
    input  logic [5:0]        win_log2,
    input  logic [31:0]       repl_hi,
    input  logic              tbl_we,
    input  logic [7:0]        tbl_idx,
    input  logic [PE_W-1:0]   tbl_pe,
    output logic              hit,
    output logic [31:0]       bus_addr,
    output logic [PE_W-1:0]   pe_num
);
    generate
        if (CPU_AW <= BUS_AW) begin : g_bad_width
            $error("CPU_AW must exceed the bus address width");
        end
    endgenerate

    typedef struct packed {
        logic            hit;
        bus_addr_t       bus;
        logic [PE_W-1:0] pe;
    } out_t;

    out_t      st_d;
    out_t      st_q;
    logic      hit_c;
    bus_addr_t bus_c;
    seg_idx_t  seg_c;
    logic [PE_W-1:0] rd_pe;

    seg_xlate_match #(.CPU_AW(CPU_AW)) u_match (
        .cpu_addr (cpu_addr),
        .win_en   (win_en),
        .win_base (win_base),
        .win_log2 (win_log2),
        .repl_hi  (repl_hi),
        .hit_c    (hit_c),
        .bus_c    (bus_c),
        .seg_c    (seg_c)
    );

    seg_xlate_table #(.PE_W(PE_W)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_we),
        .wr_idx (tbl_idx),
        .wr_pe  (tbl_pe),
        .rd_idx (seg_c),
        .rd_pe  (rd_pe)
    );

    always_comb begin
        st_d     = '0;
        st_d.hit = hit_c;
        if (hit_c) begin
            st_d.bus = bus_c;
            st_d.pe  = rd_pe;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit      = st_q.hit;
    assign bus_addr = st_q.bus;
    assign pe_num   = st_q.pe;

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_addr == '0 && pe_num == '0)); // R8
    AST_DISABLED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |=> !hit); // R3
    AST_BAD_SIZE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_log2 < 6'd28 || win_log2 > 6'd32) |=> !hit); // R3
    AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en && hit_c) |=> (bus_addr[27:0] == $past(cpu_addr[27:0]))); // R4
endmodule

// File: tb/seg_xlate_win_bench.sv
`timescale 1ns/1ps
module seg_xlate_win_bench;
    localparam int CPU_AW = 48;
    localparam int PE_W   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CPU_AW-1:0] cpu_addr = '0;
    logic              win_en = 1'b0;
    logic [CPU_AW-1:0] win_base = '0;
    logic [5:0]        win_log2 = '0;
    logic [31:0]       repl_hi = '0;
    logic              tbl_we = 1'b0;
    logic [7:0]        tbl_idx = '0;
    logic [PE_W-1:0]   tbl_pe = '0;
    logic              hit;
    logic [31:0]       bus_addr;
    logic [PE_W-1:0]   pe_num;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [PE_W-1:0] model [256];

    always #2.5 clk = ~clk;

    seg_xlate_win #(.CPU_AW(CPU_AW), .PE_W(PE_W)) u_seg_xlate_win (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .win_en(win_en),
        .win_base(win_base), .win_log2(win_log2), .repl_hi(repl_hi),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_pe(tbl_pe),
        .hit(hit), .bus_addr(bus_addr), .pe_num(pe_num)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void predict(input logic [CPU_AW-1:0] a, input logic en,
                                    input logic [CPU_AW-1:0] b, input logic [5:0] l2,
                                    input logic [31:0] rp, output logic h,
                                    output logic [31:0] ba, output logic [PE_W-1:0] pe);
        logic [63:0] m64;
        logic [31:0] m32;
        logic [7:0]  sg;
        logic        ok;
        ok  = en && (l2 >= 6'd28) && (l2 <= 6'd32);
        m64 = (64'd1 << l2) - 64'd1;
        m32 = m64[31:0];
        h   = ok && (((64'(a) ^ 64'(b)) >> l2) == 64'd0);
        sg  = ok ? 8'((a[31:0] & m32) >> (l2 - 6'd8)) : 8'd0;
        ba  = h ? ((rp & ~m32) | (a[31:0] & m32)) : 32'd0;
        pe  = h ? model[sg] : '0;
    endfunction

    task automatic apply(input string tag, input logic [CPU_AW-1:0] a, input logic en,
                         input logic [CPU_AW-1:0] b, input logic [5:0] l2,
                         input logic [31:0] rp, input logic we, input logic [7:0] wi,
                         input logic [PE_W-1:0] wp);
        logic h;
        logic [31:0] ba;
        logic [PE_W-1:0] pe;
        @(negedge clk);
        cpu_addr = a; win_en = en; win_base = b; win_log2 = l2;
        repl_hi = rp; tbl_we = we; tbl_idx = wi; tbl_pe = wp;
        predict(a, en, b, l2, rp, h, ba, pe);
        @(posedge clk);
        #1;
        if (we) model[wi] = wp;
        chk(tag, "hit", 64'(hit), 64'(h));
        chk(tag, "bus_addr", 64'(bus_addr), 64'(ba));
        chk(tag, "pe_num", 64'(pe_num), 64'(pe));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [CPU_AW-1:0] base;
        logic [CPU_AW-1:0] addr;
        logic [5:0] l2;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs zero during reset
        chk("R1", "hit", 64'(hit), 64'd0);
        chk("R1", "bus_addr", 64'(bus_addr), 64'd0);
        chk("R1", "pe_num", 64'(pe_num), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: table cleared, sweep all segments in a 4 GB window
        base = 48'h1234_0000_0000;
        for (int s = 0; s < 256; s++)
            apply("R1", base | (48'(s) << 24), 1'b1, base, 6'd32, 32'h0, 1'b0, 8'd0, '0);
        // R6: fill table while window disabled
        for (int s = 0; s < 256; s++)
            apply("R6", '0, 1'b0, '0, 6'd31, 32'h0, 1'b1, 8'(s), 8'(s) ^ 8'h5A);
        // R5 R4: 2 GB window, segment boundaries at 8 MB
        base = 48'h0000_8000_0000;
        for (int s = 0; s < 256; s += 17)
            apply("R5", base + (48'(s) << 23), 1'b1, base, 6'd31, 32'h0, 1'b0, 8'd0, '0);
        // R9: top 64 KB still forwarded, next address misses
        apply("R9", base + 48'h7FFF_FFFF, 1'b1, base, 6'd31, 32'h0, 1'b0, 8'd0, '0);
        apply("R9", base + 48'h7FFF_0000, 1'b1, base, 6'd31, 32'h0, 1'b0, 8'd0, '0);
        apply("R8", base + 48'h8000_0000, 1'b1, base, 6'd31, 32'h0, 1'b0, 8'd0, '0);
        // R4: 256 MB window with replacement upper bits
        base = 48'h00AB_3000_0000;
        apply("R4", base + 48'h0FF0_1234, 1'b1, base, 6'd28, 32'hABCD_EFFF, 1'b0, 8'd0, '0);
        apply("R4", base + 48'h0010_0000, 1'b1, base, 6'd28, 32'h5000_0000, 1'b0, 8'd0, '0);
        // R4: 4 GB window passes the low 32 bits straight through
        base = 48'h0007_0000_0000;
        apply("R4", base + 48'hDEAD_BEEF, 1'b1, base, 6'd32, 32'h1111_1111, 1'b0, 8'd0, '0);
        // R3: out-of-range sizes and disable
        apply("R3", base + 48'h10, 1'b1, base, 6'd27, 32'h0, 1'b0, 8'd0, '0);
        apply("R3", base + 48'h10, 1'b1, base, 6'd33, 32'h0, 1'b0, 8'd0, '0);
        apply("R3", base + 48'h10, 1'b0, base, 6'd32, 32'h0, 1'b0, 8'd0, '0);
        // R10: base low bits ignored
        apply("R10", base + 48'h4000_0000, 1'b1, base | 48'hFFFF_FFFF, 6'd32, 32'h0, 1'b0, 8'd0, '0);
        // R6: same-cycle write sees old value, next cycle sees new
        base = 48'h0000_8000_0000;
        apply("R6", base + (48'd9 << 23), 1'b1, base, 6'd31, 32'h0, 1'b1, 8'd9, 8'hC3);
        apply("R6", base + (48'd9 << 23), 1'b1, base, 6'd31, 32'h0, 1'b0, 8'd0, '0);
        chk("R6", "pe_after_write", 64'(pe_num), 64'hC3);
        // R7: a new input does not reach the outputs before the edge
        @(negedge clk);
        cpu_addr = '0;
        #1;
        chk("R7", "hit_held", 64'(hit), 64'd1);
        chk("R7", "pe_held", 64'(pe_num), 64'hC3);
        @(posedge clk);
        #1;
        chk("R7", "hit_after_edge", 64'(hit), 64'd0);
        // R2 R4 R5: constrained random
        for (int n = 0; n < 3000; n++) begin
            l2   = 6'(26 + ($urandom % 8));
            base = {16'($urandom), 32'($urandom)};
            addr = ($urandom % 4 != 0) ? (base ^ 48'(($urandom) & ((64'd1 << l2) - 1)))
                                       : {16'($urandom), 32'($urandom)};
            apply("R2/R4/R5", addr, ($urandom % 8) != 0, base, l2, 32'($urandom),
                  ($urandom % 3) == 0, 8'($urandom), 8'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule